// File: doc/BRIEF.md
# Two-Digit Seconds Timer with Seven-Segment Drive

This block keeps an elapsed-seconds count as two decimal digits, a units digit (0..9) and a tens digit held in a 3-bit register, and drives a seven-segment pattern for each digit. A single clock runs the whole block. A one-cycle pulse on `sec_tick` advances the count by one second. An active-low run switch, synchronised inside the block, clears the count and holds it at 00 for as long as it stays low.

A mode input selects one of two end behaviours. In wrap mode the count goes from 59 back to 00. In halt mode it climbs to 60 and then ignores ticks until the run switch is taken low. The mode is captured only while the block is held in clear. The segment outputs can be made active-high for common-cathode parts or active-low for common-anode parts.

Top module: `sec_timer_top`

## Requirements
- R1: After reset, and while the synchronised run switch is low, both digits read 0 and `halted` is low.
- R2: On a tick, a units digit below 9 goes up by one and the tens digit does not change. A units digit of 9 goes to 0.
- R3: The tens digit goes up by one only on the tick where the units digit rolls from 9 to 0.
- R4: In wrap mode (captured `wrap_mode`=1), a tick at 59 gives 00.
- R5: In halt mode (captured `wrap_mode`=0), the count stops at 60 (tens=6, units=0), further ticks leave it at 60, and `halted`=1.
- R6: `run_n` goes through a two-flop synchroniser. A change on `run_n` reaches the counter on the third clock edge. Taking it low from 60 clears the count to 00 and drops `halted`.
- R7: `wrap_mode` is sampled only while the block is held in clear. Changing it during a count has no effect until the next clear.
- R8: Segment bits are {g,f,e,d,c,b,a} = bit6..bit0, using the standard patterns for 0..9. For example 0=7'h3F, 1=7'h06, 6=7'h7D, 9=7'h6F. A digit value above 9 lights no segment.
- R9: With `seg_inv`=1 every segment bit is inverted (active-low). With `seg_inv`=0 the bits are active-high.
- R10: Cycles without `sec_tick` leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sec_tick | input | 1 | One-cycle advance enable |
| run_n | input | 1 | Run switch, low = clear and hold |
| wrap_mode | input | 1 | 1 = wrap 59 to 00, 0 = halt at 60 |
| seg_inv | input | 1 | 1 = active-low segment outputs |
| units_val | output | 4 | Units digit value |
| tens_val | output | 3 | Tens digit value |
| units_seg | output | 7 | Units digit segments {g..a} |
| tens_seg | output | 7 | Tens digit segments {g..a} |
| halted | output | 1 | Count is frozen at 60 in halt mode |

## Verification
The bench walks the count through both decade rollovers, the 59 boundary in each mode, and the hold at 60 under repeated ticks. A tens carry taken from the wrong condition would give a count such as 11 after 10, and a missing wrap would show 60 in wrap mode. A mode change made mid-count is checked so that a design sampling the mode live would halt or wrap at the wrong moment. The bench also counts the synchroniser latency of the run switch, and it checks both segment polarities so that a swapped inversion or a wrong glyph is caught.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
  localparam int UNITS_W = 4;
  localparam int TENS_W  = 3;
  localparam int SEG_W   = 7;
  localparam int UNITS_MAX = 9;
  localparam int TENS_LIMIT = 6;

  function automatic logic [SEG_W-1:0] glyph(input logic [UNITS_W-1:0] d);
    logic [SEG_W-1:0] s;
    case (d)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

  function automatic logic [UNITS_W-1:0] units_next(input logic [UNITS_W-1:0] u);
    return (u >= UNITS_W'(UNITS_MAX)) ? '0 : u + 1'b1;
  endfunction
endpackage

// File: rtl/sec_run_sync.sv
module sec_run_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], din};
  end
  assign dout = sh[STAGES-1];
endmodule

// File: rtl/sec_seg_drive.sv
module sec_seg_drive
  import sec_timer_pkg::*;
(
  input  logic [UNITS_W-1:0] digit,
  input  logic               inv,
  output logic [SEG_W-1:0]   seg
);
  always_comb seg = inv ? ~glyph(digit) : glyph(digit);
endmodule

// File: rtl/sec_digit_count.sv
module sec_digit_count
  import sec_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic               wrap_sel,
  output logic [UNITS_W-1:0] units,
  output logic [TENS_W-1:0]  tens,
  output logic               frozen,
  output logic               adv,
  output logic               carry
);
  logic at_limit;
  assign at_limit = (tens == TENS_W'(TENS_LIMIT));
  assign frozen   = at_limit && !wrap_sel;
  assign adv      = tick && !clr && !frozen;
  assign carry    = adv && (units == UNITS_W'(UNITS_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units <= '0;
      tens  <= '0;
    end else if (clr) begin
      units <= '0;
      tens  <= '0;
    end else if (adv) begin
      units <= units_next(units);
      if (carry) begin
        if (wrap_sel && tens == TENS_W'(TENS_LIMIT-1)) tens <= '0;
        else                                           tens <= tens + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sec_timer_top.sv
module sec_timer_top
  import sec_timer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  input  logic               run_n,
  input  logic               wrap_mode,
  input  logic               seg_inv,
  output logic [UNITS_W-1:0] units_val,
  output logic [TENS_W-1:0]  tens_val,
  output logic [SEG_W-1:0]   units_seg,
  output logic [SEG_W-1:0]   tens_seg,
  output logic               halted
);
  logic run_s, clr, wrap_q, adv, carry, frozen;
  logic [UNITS_W-1:0] tens_ext;

  sec_run_sync #(.STAGES(2)) u_sync (.clk(clk), .rst_n(rst_n), .din(run_n), .dout(run_s));
  assign clr = !run_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wrap_q <= 1'b1;
    else if (clr) wrap_q <= wrap_mode;
  end

  sec_digit_count u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(sec_tick), .wrap_sel(wrap_q),
    .units(units_val), .tens(tens_val), .frozen(frozen), .adv(adv), .carry(carry));

  assign halted   = frozen && !clr;
  assign tens_ext = {1'b0, tens_val};

  sec_seg_drive u_seg_u (.digit(units_val), .inv(seg_inv), .seg(units_seg));
  sec_seg_drive u_seg_t (.digit(tens_ext),  .inv(seg_inv), .seg(tens_seg));
endmodule

// File: rtl/sec_timer_chk.sv
module sec_timer_chk
  import sec_timer_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               sec_tick,
  input logic               clr,
  input logic               adv,
  input logic               carry,
  input logic               halted,
  input logic [UNITS_W-1:0] units_val,
  input logic [TENS_W-1:0]  tens_val
);
  p_units_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    units_val <= UNITS_W'(UNITS_MAX));
  p_tens_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tens_val <= TENS_W'(TENS_LIMIT));
  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (units_val == '0 && tens_val == '0));
  p_tens_only_on_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry && !clr) |=> $stable(tens_val));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !clr) |=> ($stable(units_val) && $stable(tens_val)));
  p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clr) |=> (tens_val == 3'd6 && units_val == 4'd0));
  p_halt_no_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !adv);
endmodule

bind sec_timer_top sec_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .clr(clr), .adv(adv),
  .carry(carry), .halted(halted), .units_val(units_val), .tens_val(tens_val));

// File: tb/tb_sec_timer_top.sv
module tb_sec_timer_top;
  logic clk = 0, rst_n = 0, sec_tick = 0, run_n = 0, wrap_mode = 1, seg_inv = 0;
  logic [3:0] units_val;
  logic [2:0] tens_val;
  logic [6:0] units_seg, tens_seg;
  logic halted;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sec_timer_top dut (.clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .run_n(run_n),
    .wrap_mode(wrap_mode), .seg_inv(seg_inv), .units_val(units_val), .tens_val(tens_val),
    .units_seg(units_seg), .tens_seg(tens_seg), .halted(halted));

  // Expected glyphs written as lit-segment lists: {g,f,e,d,c,b,a}
  function automatic logic [6:0] ref_seg(input int d);
    case (d)
      0: return 7'b0111111;  1: return 7'b0000110;  2: return 7'b1011011;
      3: return 7'b1001111;  4: return 7'b1100110;  5: return 7'b1101101;
      6: return 7'b1111101;  7: return 7'b0000111;  8: return 7'b1111111;
      9: return 7'b1101111;  default: return 7'b0000000;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic t);
    @(negedge clk); sec_tick = t;
    @(posedge clk); #1; sec_tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  task automatic clear_with(input logic m);
    @(negedge clk); run_n = 0; wrap_mode = m;
    repeat (4) @(posedge clk);
    @(negedge clk); run_n = 1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Vector table: {ticks from 00, wrap mode, expected tens, expected units, expected halted}
  typedef struct packed { logic [7:0] n; logic m; logic [2:0] t; logic [3:0] u; logic h; } vec_t;
  localparam vec_t VT [8] = '{
    '{8'd1,   1'b1, 3'd0, 4'd1, 1'b0},
    '{8'd9,   1'b1, 3'd0, 4'd9, 1'b0},
    '{8'd10,  1'b1, 3'd1, 4'd0, 1'b0},
    '{8'd59,  1'b1, 3'd5, 4'd9, 1'b0},
    '{8'd60,  1'b1, 3'd0, 4'd0, 1'b0},
    '{8'd73,  1'b1, 3'd1, 4'd3, 1'b0},
    '{8'd60,  1'b0, 3'd6, 4'd0, 1'b1},
    '{8'd75,  1'b0, 3'd6, 4'd0, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk); #1;
    chk("R1 units", units_val, 0); chk("R1 tens", tens_val, 0); chk("R1 halted", halted, 0);
    chk("R8 units seg 0", units_seg, ref_seg(0));

    foreach (VT[k]) begin
      clear_with(VT[k].m);
      ticks(VT[k].n);
      chk("R2/R3/R4/R5 table tens", tens_val, VT[k].t);
      chk("R2/R3/R4/R5 table units", units_val, VT[k].u);
      chk("R5 table halted", halted, VT[k].h);
    end

    // R3: tens unchanged across 1..9, steps only at rollover
    clear_with(1);
    ticks(8); chk("R3 tens before carry", tens_val, 0);
    ticks(1); chk("R3 tens at 9", tens_val, 0);
    ticks(1); chk("R3 tens after carry", tens_val, 1);

    // R10: idle cycles
    repeat (5) step(1'b0);
    chk("R10 idle units", units_val, 0); chk("R10 idle tens", tens_val, 1);

    // R7: mode change mid-count ignored (captured wrap)
    wrap_mode = 0;
    ticks(50); chk("R7 still wraps tens", tens_val, 0); chk("R7 still wraps units", units_val, 0);
    chk("R7 not halted", halted, 0);

    // R6: halt at 60, then clear latency
    clear_with(0);
    ticks(60); chk("R5 halted", halted, 1);
    @(negedge clk); run_n = 0;
    @(posedge clk); #1; chk("R6 edge1 held", tens_val, 6);
    @(posedge clk); #1; chk("R6 edge2 held", tens_val, 6);
    @(posedge clk); #1; chk("R6 edge3 cleared tens", tens_val, 0);
    chk("R6 cleared units", units_val, 0); chk("R6 halted low", halted, 0);
    // ticks while held ignored (R1)
    ticks(4); chk("R1 held at 00", units_val, 0);
    @(negedge clk); run_n = 1; repeat (3) @(posedge clk); #1;

    // R8/R9 segment glyphs and polarity
    clear_with(1);
    for (int d = 0; d < 10; d++) begin
      @(negedge clk); seg_inv = 0; #1;
      chk("R8 units glyph", units_seg, ref_seg(d));
      seg_inv = 1; #1;
      chk("R9 inverted glyph", units_seg, {25'd0, ~ref_seg(d)});
      seg_inv = 0;
      step(1'b1);
    end
    clear_with(0); ticks(60); #1;
    chk("R8 tens glyph 6", tens_seg, ref_seg(6));
    seg_inv = 1; #1;
    chk("R9 tens inverted 6", tens_seg, {25'd0, ~ref_seg(6)});
    seg_inv = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule